// File: doc/BRIEF.md
# Raster Pixel Stream with Serial Overlay

This block produces the raster timing for a video output that a processor drives directly. Each clock yields one 6-bit pixel. A free-running horizontal counter and a line counter generate the sync pulses. A visible flag blanks the expanded colour output outside the active picture. The pixel normally follows the low six bits of a processor-written colour port, which the block samples on every clock.

A write to the serial data register starts an overlay of 16 clocks. The written byte is sent out most significant bit first, and each bit lasts two clocks. While a bit is 0 the pixel is forced to all ones (full white). While a bit is 1 the port value passes through. At the end of the window the held byte is cleared.

The overlay is run by a two-state machine:
- `OVL_IDLE`: no window is active.
- `OVL_SHIFT`: a window is in progress.

Its transitions are:
- *start/restart*: any write, from either state, enters `OVL_SHIFT` with the new byte.
- *expire*: the last clock of the last bit returns the machine to `OVL_IDLE` and zeroes the byte.

Each 6-bit pixel is also expanded to 24-bit RGB. The expansion multiplies each 2-bit level by 0x55.

Top module: `raster_overlay_video`

## Requirements
- R1: `hcount_o` counts 0 to H_VIS+H_SYNC-1 (default 634), one step per clock, then wraps to 0.
- R2: `vcount_o` advances by one only on the clock where `hcount_o` wraps. It counts 0 to V_VIS+V_SYNC-1 (default 524), then wraps to 0.
- R3: `hsync_o` is high exactly while `hcount_o` >= H_VIS (default 480).
- R4: `vsync_o` is high exactly while `vcount_o` >= V_VIS (default 480).
- R5: With no overlay active, `pixel_o` equals `port_i[5:0]`. Port bits 7:6 have no effect.
- R6: A write strobe on `spi_wr_i` captured at a clock edge starts an overlay in the next cycle. The overlay lasts 16 cycles. Cycle k (0..15) uses data bit 7 - k/2, so each bit is shown for two cycles, MSB first.
- R7: During the overlay, a data bit of 0 gives `pixel_o` = 6'h3F, and a data bit of 1 gives `pixel_o` = `port_i[5:0]`.
- R8: After the 16th overlay cycle the window ends, the held byte is cleared, and `pixel_o` follows the port again.
- R9: A write during an active overlay restarts the 16-cycle window with the new byte.
- R10: `rgb_o` = {R,G,B}. R is `pixel[5:4]`*0x55 in bits 23:16, G is `pixel[3:2]`*0x55 in bits 15:8, and B is `pixel[1:0]`*0x55 in bits 7:0.
- R11: `rgb_o` is 0 whenever `hcount_o` >= H_VIS or `vcount_o` >= V_VIS.
- R12: Reset (active-low `rst_n`) sets both counters to 0 and cancels any overlay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_i | input | 8 | Colour port value; the low 6 bits are the pixel |
| spi_wr_i | input | 1 | Serial data register write strobe |
| spi_data_i | input | 8 | Byte written to the serial data register |
| pixel_o | output | 6 | Current 6-bit pixel |
| rgb_o | output | 24 | Expanded RGB, blanked outside the visible area |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| hcount_o | output | 10 | Clock position within the line |
| vcount_o | output | 10 | Line position within the frame |

## Verification
The overlay assertions assume that `spi_wr_i` is a clean one-cycle level sampled at the clock edge. They also assume the byte on `spi_data_i` is stable while the strobe is high. Nothing is assumed about how often writes arrive, because a restart is legal in any cycle. The bench changes inputs only on the falling edge and pulses the strobe for exactly one cycle. It uses a small raster so that a full frame wrap is exercised quickly.

// File: rtl/raster_pkg.sv
package raster_pkg;
    typedef enum logic {
        OVL_IDLE  = 1'b0,
        OVL_SHIFT = 1'b1
    } ovl_state_e;
endpackage

// File: rtl/raster_timing.sv
module raster_timing #(
    parameter int H_VIS  = 480,
    parameter int H_SYNC = 155,
    parameter int V_VIS  = 480,
    parameter int V_SYNC = 45,
    parameter int HW     = 10,
    parameter int VW     = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] hcount_o,
    output logic [VW-1:0] vcount_o,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          visible_o
);
    localparam int LINE  = H_VIS + H_SYNC;
    localparam int FRAME = V_VIS + V_SYNC;
    localparam logic [HW-1:0] H_LAST  = HW'(LINE - 1);
    localparam logic [VW-1:0] V_LAST  = VW'(FRAME - 1);
    localparam logic [HW-1:0] H_BOUND = HW'(H_VIS);
    localparam logic [VW-1:0] V_BOUND = VW'(V_VIS);

    logic [HW-1:0] h_q;
    logic [VW-1:0] v_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
            v_q <= '0;
        end else if (h_q == H_LAST) begin
            h_q <= '0;
            v_q <= (v_q == V_LAST) ? '0 : v_q + 1'b1;
        end else begin
            h_q <= h_q + 1'b1;
        end
    end

    always_comb begin
        hcount_o  = h_q;
        vcount_o  = v_q;
        hsync_o   = (h_q >= H_BOUND);
        vsync_o   = (v_q >= V_BOUND);
        visible_o = (h_q < H_BOUND) && (v_q < V_BOUND);
    end

    // R1
    hcnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_q == H_LAST) |=> (h_q == '0));
    // R1
    hcnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_q != H_LAST) |=> (h_q == $past(h_q) + 1'b1));
    // R2
    vcnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_q != H_LAST) |=> $stable(v_q));
    // R2
    vcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q <= V_LAST));
endmodule

// File: rtl/spi_overlay.sv
module spi_overlay
    import raster_pkg::*;
#(
    parameter int OVL_BITS     = 8,
    parameter int CLKS_PER_BIT = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [OVL_BITS-1:0] wdata_i,
    output logic                active_o,
    output logic                force_o
);
    localparam int PW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam int BW = (OVL_BITS > 1) ? $clog2(OVL_BITS) : 1;
    localparam logic [PW-1:0] P_LAST = PW'(CLKS_PER_BIT - 1);
    localparam logic [BW-1:0] B_LAST = BW'(OVL_BITS - 1);

    ovl_state_e          state_q, state_d;
    logic [OVL_BITS-1:0] shreg_q, shreg_d;
    logic [PW-1:0]       phase_q, phase_d;
    logic [BW-1:0]       bits_q, bits_d;

    always_comb begin
        state_d = state_q;
        shreg_d = shreg_q;
        phase_d = phase_q;
        bits_d  = bits_q;
        if (wr_i) begin
            state_d = OVL_SHIFT;
            shreg_d = wdata_i;
            phase_d = '0;
            bits_d  = '0;
        end else begin
            unique case (state_q)
                OVL_IDLE: begin
                end
                OVL_SHIFT: begin
                    if (phase_q == P_LAST) begin
                        phase_d = '0;
                        if (bits_q == B_LAST) begin
                            state_d = OVL_IDLE;
                            shreg_d = '0;
                            bits_d  = '0;
                        end else begin
                            bits_d  = bits_q + 1'b1;
                            shreg_d = shreg_q << 1;
                        end
                    end else begin
                        phase_d = phase_q + 1'b1;
                    end
                end
                default: state_d = OVL_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OVL_IDLE;
            shreg_q <= '0;
            phase_q <= '0;
            bits_q  <= '0;
        end else begin
            state_q <= state_d;
            shreg_q <= shreg_d;
            phase_q <= phase_d;
            bits_q  <= bits_d;
        end
    end

    always_comb begin
        active_o = (state_q == OVL_SHIFT);
        force_o  = (state_q == OVL_SHIFT) && !shreg_q[OVL_BITS-1];
    end

    // R6 R9
    ovl_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (state_q == OVL_SHIFT && phase_q == '0 && bits_q == '0 && shreg_q == $past(wdata_i)));
    // R8
    ovl_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OVL_SHIFT && phase_q == P_LAST && bits_q == B_LAST && !wr_i)
        |=> (state_q == OVL_IDLE && shreg_q == '0));
    // R6
    ovl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OVL_SHIFT && phase_q != P_LAST && !wr_i) |=> $stable(shreg_q));
endmodule

// File: rtl/pixel_expand.sv
module pixel_expand #(
    parameter int CH_BITS = 2,
    localparam int PIX_W  = 3 * CH_BITS,
    localparam int REP    = 8 / CH_BITS
) (
    input  logic [PIX_W-1:0] pixel_i,
    input  logic             visible_i,
    output logic [23:0]      rgb_o
);
    logic [23:0] full;

    for (genvar c = 0; c < 3; c++) begin : g_chan
        assign full[c*8 +: 8] = {REP{pixel_i[c*CH_BITS +: CH_BITS]}};
    end

    assign rgb_o = visible_i ? full : 24'h0;
endmodule

// File: rtl/raster_overlay_video.sv
module raster_overlay_video #(
    parameter int H_VIS        = 480,
    parameter int H_SYNC       = 155,
    parameter int V_VIS        = 480,
    parameter int V_SYNC       = 45,
    parameter int PORT_W       = 8,
    parameter int CH_BITS      = 2,
    parameter int OVL_BITS     = 8,
    parameter int CLKS_PER_BIT = 2,
    localparam int PIX_W       = 3 * CH_BITS,
    localparam int HW          = $clog2(H_VIS + H_SYNC),
    localparam int VW          = $clog2(V_VIS + V_SYNC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PORT_W-1:0]   port_i,
    input  logic                spi_wr_i,
    input  logic [OVL_BITS-1:0] spi_data_i,
    output logic [PIX_W-1:0]    pixel_o,
    output logic [23:0]         rgb_o,
    output logic                hsync_o,
    output logic                vsync_o,
    output logic [HW-1:0]       hcount_o,
    output logic [VW-1:0]       vcount_o
);
    logic visible;
    logic ovl_active;
    logic ovl_force;

    raster_timing #(
        .H_VIS(H_VIS), .H_SYNC(H_SYNC), .V_VIS(V_VIS), .V_SYNC(V_SYNC),
        .HW(HW), .VW(VW)
    ) u_timing (
        .clk(clk), .rst_n(rst_n),
        .hcount_o(hcount_o), .vcount_o(vcount_o),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .visible_o(visible)
    );

    spi_overlay #(.OVL_BITS(OVL_BITS), .CLKS_PER_BIT(CLKS_PER_BIT)) u_overlay (
        .clk(clk), .rst_n(rst_n),
        .wr_i(spi_wr_i), .wdata_i(spi_data_i),
        .active_o(ovl_active), .force_o(ovl_force)
    );

    assign pixel_o = ovl_force ? {PIX_W{1'b1}} : port_i[PIX_W-1:0];

    pixel_expand #(.CH_BITS(CH_BITS)) u_expand (
        .pixel_i(pixel_o), .visible_i(visible), .rgb_o(rgb_o)
    );

    // R5
    idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ovl_active |-> (pixel_o == port_i[PIX_W-1:0]));
    // R11
    blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync_o || vsync_o) |-> (rgb_o == 24'h0));
endmodule

// File: tb/tb_raster_overlay_video.sv
module tb_raster_overlay_video;
    localparam int HV = 8, HS = 4, VV = 4, VS = 2;
    localparam int LINE = HV + HS, FRAME = VV + VS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  port = 8'h00;
    logic        wr = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [5:0]  pixel;
    logic [23:0] rgb;
    logic        hsync, vsync;
    logic [3:0]  hcount;
    logic [2:0]  vcount;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    raster_overlay_video #(.H_VIS(HV), .H_SYNC(HS), .V_VIS(VV), .V_SYNC(VS)) dut (
        .clk(clk), .rst_n(rst_n), .port_i(port), .spi_wr_i(wr), .spi_data_i(wdata),
        .pixel_o(pixel), .rgb_o(rgb), .hsync_o(hsync), .vsync_o(vsync),
        .hcount_o(hcount), .vcount_o(vcount)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] expand(logic [5:0] p);
        return {8'(p[5:4] * 8'h55), 8'(p[3:2] * 8'h55), 8'(p[1:0] * 8'h55)};
    endfunction

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr = 1'b0;
        step();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic t_reset_state();
        port = 8'h12;
        do_reset();
        check("R12 hcount", 32'(hcount), 0);
        check("R12 vcount", 32'(vcount), 0);
        check("R12 pixel", 32'(pixel), 32'h12);
        check("R3 hsync", 32'(hsync), 0);
        check("R4 vsync", 32'(vsync), 0);
    endtask

    task automatic t_timing();
        int eh = 0, ev = 0;
        port = 8'h2D;
        do_reset();
        for (int i = 0; i < 2 * LINE * FRAME + 5; i++) begin
            check("R1 hcount", 32'(hcount), 32'(eh));
            check("R2 vcount", 32'(vcount), 32'(ev));
            check("R3 hsync", 32'(hsync), 32'(eh >= HV));
            check("R4 vsync", 32'(vsync), 32'(ev >= VV));
            if (eh < HV && ev < VV) check("R10 rgb", 32'(rgb), 32'(expand(6'h2D)));
            else check("R11 blank", 32'(rgb), 0);
            step();
            if (eh == LINE - 1) begin
                eh = 0;
                ev = (ev == FRAME - 1) ? 0 : ev + 1;
            end else eh++;
        end
    endtask

    task automatic t_port_upper();
        port = 8'hC5; #1;
        check("R5 upper ignored", 32'(pixel), 32'h05);
        port = 8'h05; #1;
        check("R5 pass", 32'(pixel), 32'h05);
    endtask

    task automatic start_write(logic [7:0] d);
        wdata = d;
        wr = 1'b1;
        step();
        wr = 1'b0;
    endtask

    task automatic check_window(logic [7:0] d, logic [7:0] p);
        for (int k = 0; k < 16; k++) begin
            check(d[7 - k/2] ? "R7 bit1 pass" : "R6 R7 bit0 white",
                  32'(pixel), d[7 - k/2] ? 32'(p[5:0]) : 32'h3F);
            step();
        end
        check("R8 window end", 32'(pixel), 32'(p[5:0]));
    endtask

    task automatic t_overlay(logic [7:0] d);
        port = 8'h92;
        @(negedge clk);
        start_write(d);
        check_window(d, port);
        step();
        check("R8 stays idle", 32'(pixel), 32'h12);
    endtask

    task automatic t_restart();
        port = 8'h21;
        @(negedge clk);
        start_write(8'h00);
        for (int k = 0; k < 5; k++) begin
            check("R6 first window", 32'(pixel), 32'h3F);
            step();
        end
        start_write(8'h96);
        check_window(8'h96, port);
    endtask

    task automatic t_rgb_levels();
        do_reset();
        for (int v = 0; v < 64; v++) begin
            while (!(hcount < 4'(HV) && vcount < 3'(VV))) step();
            port = 8'(v) | 8'h40;
            #1;
            check("R10 expand", 32'(rgb), 32'(expand(6'(v))));
            step();
        end
    endtask

    task automatic t_reset_mid();
        port = 8'h0A;
        @(negedge clk);
        start_write(8'h00);
        step();
        check("R12 pre overlay", 32'(pixel), 32'h3F);
        rst_n = 1'b0;
        #1;
        check("R12 overlay cancelled", 32'(pixel), 32'h0A);
        check("R12 hcount cleared", 32'(hcount), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step();
        check("R12 restart count", 32'(hcount), 1);
        check("R12 idle after", 32'(pixel), 32'h0A);
    endtask

    initial begin
        t_reset_state();
        t_timing();
        t_port_upper();
        t_overlay(8'hA5);
        t_overlay(8'h00);
        t_overlay(8'hFF);
        t_restart();
        t_rgb_levels();
        t_reset_mid();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule